// File: doc/BRIEF.md
# Soft-Symbol Half-Burst Correlator

This block sits beside an iterative channel decoder and builds the correlation sums that a later stage turns into carrier frequency and phase estimates. After each decoder pass it takes, per clock, one pair of soft bit decisions (log-likelihood ratios) together with the received complex sample for the same symbol position. It maps each ratio through a hyperbolic-tangent table into one component of a soft QPSK reference symbol. It then removes the modulation by multiplying the received sample with the conjugate of that reference symbol.

The products from the front half of the burst are summed into one complex accumulator and those from the rear half into a second one. A burst begins with a one-cycle start request that carries the burst length. It ends with a one-cycle completion pulse, after which both sums stay still until the next burst. Lengths that are odd, zero or above the design maximum are refused with an error flag.

Top module: `ca_halfburst_corr`

## Requirements
- R1: Each accepted symbol takes both ratios in the same cycle: `llr_even_i` (index 2l) forms the real part and `llr_odd_i` (index 2l+1) the imaginary part of the soft symbol. A burst of length L accepts exactly L symbols, one per cycle in which `valid_i` is high while a burst runs.
- R2: A ratio code v is a two's complement integer with LLR_FRAC fractional bits. It maps to round(tanh(v / 2^(LLR_FRAC+1)) * (2^(SOFT_W-1) - 1)), rounding half away from zero. The mapping comes from a table built at elaboration.
- R3: Each product is r times conj(s): real part = rr*sr + ri*si, imaginary part = ri*sr - rr*si.
- R4: Symbols with index 0 to L/2-1 add into the front sum (`z0_*`). Symbols with index L/2 to L-1 add into the rear sum (`z1_*`). A symbol never touches the other sum.
- R5: After reset, and in the cycle after an accepted start, all four sum outputs read zero. A start is accepted when `start_i` is high while `busy_o` is low, and `len_i` is latched at that edge.
- R6: If the last symbol is accepted at clock edge k, the sums are final after edge k+1 and `done_o` is high for exactly that one cycle. The sums then hold until the next accepted start.
- R7: A length is valid only if it is even, non-zero and at most MAX_LEN. An accepted start with any other length sets `err_o`, runs no burst and leaves the sums at zero. `err_o` stays high until the next accepted start with a valid length, which clears it.
- R8: `start_i` while `busy_o` is high is ignored and does not change the running burst. `valid_i` while no burst runs is ignored and does not change any sum.
- R9: The sums cannot overflow. Each accumulator is wide enough for MAX_LEN/2 products of the largest magnitude.
- R10: `busy_o` is high from the edge after an accepted valid start until the edge at which `done_o` rises. It is low in the cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst with length `len_i` |
| len_i | input | LEN_W | Burst length L in symbols |
| valid_i | input | 1 | Symbol inputs carry a symbol this cycle |
| llr_even_i | input | LLR_W | Signed ratio for the real component |
| llr_odd_i | input | LLR_W | Signed ratio for the imaginary component |
| rx_re_i | input | SYM_W | Received sample, real part (signed) |
| rx_im_i | input | SYM_W | Received sample, imaginary part (signed) |
| busy_o | output | 1 | A burst is in progress |
| done_o | output | 1 | One-cycle burst completion pulse |
| err_o | output | 1 | Last start carried an invalid length |
| z0_re_o | output | ACC_W | Front-half sum, real part (signed) |
| z0_im_o | output | ACC_W | Front-half sum, imaginary part (signed) |
| z1_re_o | output | ACC_W | Rear-half sum, real part (signed) |
| z1_im_o | output | ACC_W | Rear-half sum, imaginary part (signed) |

## Verification
The assertions take for granted that `rst_n` is held low over at least one clock edge before use. They also assume that every input is stable around each rising edge, so that a start, its length and each symbol are seen by exactly one edge. The stimulus changes all inputs only on falling edges and releases reset on a falling edge. It issues its one deliberate start during a running burst only to test that the start is ignored. The half-routing and hold properties assume no symbol is in flight when a new start would be taken; the control refuses such starts by design, and the bench always waits for `busy_o` to fall before its intended starts.

// File: rtl/ca_corr_pkg.sv
package ca_corr_pkg;

   // Table entry for one ratio code v: scaled tanh(v / 2^(frac+1)),
   // rounded half away from zero.
   function automatic int tanh_code(input int v, input int frac, input int soft_w);
      real x;
      real y;
      x = real'(v) / real'(2 ** (frac + 1));
      y = $tanh(x) * real'((2 ** (soft_w - 1)) - 1);
      if (y >= 0.0) return int'($floor(y + 0.5));
      else          return -int'($floor(-y + 0.5));
   endfunction

endpackage

// File: rtl/ca_tanh_lut.sv
module ca_tanh_lut #(
   parameter int LLR_W    = 6,
   parameter int LLR_FRAC = 2,
   parameter int SOFT_W   = 8
) (
   input  logic [LLR_W-1:0]         llr_i,
   output logic signed [SOFT_W-1:0] soft_o
);
   localparam int N = 1 << LLR_W;

   logic [N-1:0][SOFT_W-1:0] tbl;

   for (genvar i = 0; i < N; i++) begin : g_ent
      localparam int V = (i >= N / 2) ? i - N : i;
      localparam int C = ca_corr_pkg::tanh_code(V, LLR_FRAC, SOFT_W);
      assign tbl[i] = SOFT_W'(C);
   end

   assign soft_o = tbl[llr_i];
endmodule

// File: rtl/ca_cmac.sv
module ca_cmac #(
   parameter int SYM_W  = 10,
   parameter int SOFT_W = 8,
   localparam int PROD_W = SYM_W + SOFT_W + 1
) (
   input  logic signed [SYM_W-1:0]  rr_i,
   input  logic signed [SYM_W-1:0]  ri_i,
   input  logic signed [SOFT_W-1:0] sr_i,
   input  logic signed [SOFT_W-1:0] si_i,
   output logic signed [PROD_W-1:0] p_re_o,
   output logic signed [PROD_W-1:0] p_im_o
);
   localparam int M_W = SYM_W + SOFT_W;

   logic signed [M_W-1:0] m_rr, m_ii, m_ir, m_ri;

   assign m_rr = rr_i * sr_i;
   assign m_ii = ri_i * si_i;
   assign m_ir = ri_i * sr_i;
   assign m_ri = rr_i * si_i;

   // conjugate on the soft symbol
   assign p_re_o = PROD_W'(m_rr) + PROD_W'(m_ii);
   assign p_im_o = PROD_W'(m_ir) - PROD_W'(m_ri);
endmodule

// File: rtl/ca_burst_ctrl.sv
module ca_burst_ctrl #(
   parameter int MAX_LEN = 2048,
   parameter int LEN_W   = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             valid_i,
   input  logic             pipe_busy_i,
   output logic             clr_o,
   output logic             acc_o,
   output logic             half_o,
   output logic             last_o,
   output logic             busy_o,
   output logic             err_o
);
   logic             run_q;
   logic             err_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] idx_q;
   logic             len_ok;

   assign busy_o = run_q | pipe_busy_i;
   assign clr_o  = start_i & ~busy_o;
   assign len_ok = ~len_i[0] && (len_i != '0) && (len_i <= LEN_W'(MAX_LEN));
   assign acc_o  = run_q & valid_i;
   assign half_o = idx_q >= (len_q >> 1);
   assign last_o = idx_q == (len_q - 1'b1);
   assign err_o  = err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         err_q <= 1'b0;
         len_q <= '0;
         idx_q <= '0;
      end else if (clr_o) begin
         err_q <= ~len_ok;
         run_q <= len_ok;
         len_q <= len_i;
         idx_q <= '0;
      end else if (acc_o) begin
         idx_q <= idx_q + 1'b1;
         if (last_o) run_q <= 1'b0;
      end
   end

   // R1
   idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (idx_q < len_q));
   // R7
   bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_o && !len_ok) |=> (err_o && !busy_o));
   // R8
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_o) |=> ($stable(err_o) && $stable(len_q)));
endmodule

// File: rtl/ca_halfburst_corr.sv
module ca_halfburst_corr #(
   parameter int LLR_W    = 6,
   parameter int LLR_FRAC = 2,
   parameter int SOFT_W   = 8,
   parameter int SYM_W    = 10,
   parameter int MAX_LEN  = 2048,
   localparam int LEN_W   = $clog2(MAX_LEN + 1),
   localparam int PROD_W  = SYM_W + SOFT_W + 1,
   localparam int ACC_W   = PROD_W + $clog2(MAX_LEN / 2)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [LEN_W-1:0]        len_i,
   input  logic                    valid_i,
   input  logic signed [LLR_W-1:0] llr_even_i,
   input  logic signed [LLR_W-1:0] llr_odd_i,
   input  logic signed [SYM_W-1:0] rx_re_i,
   input  logic signed [SYM_W-1:0] rx_im_i,
   output logic                    busy_o,
   output logic                    done_o,
   output logic                    err_o,
   output logic signed [ACC_W-1:0] z0_re_o,
   output logic signed [ACC_W-1:0] z0_im_o,
   output logic signed [ACC_W-1:0] z1_re_o,
   output logic signed [ACC_W-1:0] z1_im_o
);
   // elaboration checks
   if (LLR_W < 2 || LLR_W > 10) begin : g_bad_llr
      $error("LLR_W must lie in 2..10");
   end
   if (SOFT_W < 2 || SOFT_W > 16) begin : g_bad_soft
      $error("SOFT_W must lie in 2..16");
   end
   if (SYM_W < 2) begin : g_bad_sym
      $error("SYM_W must be at least 2");
   end
   if (MAX_LEN < 2 || (MAX_LEN % 2) != 0) begin : g_bad_len
      $error("MAX_LEN must be even and at least 2");
   end
   if (LLR_FRAC < 0) begin : g_bad_frac
      $error("LLR_FRAC must not be negative");
   end

   logic clr, acc, half, last;
   logic signed [SOFT_W-1:0] s_re, s_im;

   // stage 1: soft symbol and sample
   logic                     s1_vld, s1_half, s1_last;
   logic signed [SOFT_W-1:0] s1_sre, s1_sim;
   logic signed [SYM_W-1:0]  s1_rre, s1_rim;
   logic signed [PROD_W-1:0] p_re, p_im;
   logic                     done_q;

   ca_burst_ctrl #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
      .valid_i(valid_i), .pipe_busy_i(s1_vld), .clr_o(clr), .acc_o(acc),
      .half_o(half), .last_o(last), .busy_o(busy_o), .err_o(err_o));

   ca_tanh_lut #(.LLR_W(LLR_W), .LLR_FRAC(LLR_FRAC), .SOFT_W(SOFT_W)) u_lut_re (
      .llr_i(llr_even_i), .soft_o(s_re));
   ca_tanh_lut #(.LLR_W(LLR_W), .LLR_FRAC(LLR_FRAC), .SOFT_W(SOFT_W)) u_lut_im (
      .llr_i(llr_odd_i), .soft_o(s_im));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_half <= 1'b0;
         s1_last <= 1'b0;
         s1_sre  <= '0;
         s1_sim  <= '0;
         s1_rre  <= '0;
         s1_rim  <= '0;
         done_q  <= 1'b0;
      end else begin
         s1_vld <= acc;
         done_q <= s1_vld & s1_last;
         if (acc) begin
            s1_half <= half;
            s1_last <= last;
            s1_sre  <= s_re;
            s1_sim  <= s_im;
            s1_rre  <= rx_re_i;
            s1_rim  <= rx_im_i;
         end
      end
   end

   ca_cmac #(.SYM_W(SYM_W), .SOFT_W(SOFT_W)) u_cmac (
      .rr_i(s1_rre), .ri_i(s1_rim), .sr_i(s1_sre), .si_i(s1_sim),
      .p_re_o(p_re), .p_im_o(p_im));

   // stage 2: one accumulator pair per burst half
   for (genvar h = 0; h < 2; h++) begin : g_half
      logic signed [ACC_W-1:0] a_re, a_im;
      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            a_re <= '0;
            a_im <= '0;
         end else if (s1_vld && (s1_half == 1'(h))) begin
            a_re <= a_re + ACC_W'(p_re);
            a_im <= a_im + ACC_W'(p_im);
         end
      end
   end

   assign z0_re_o = g_half[0].a_re;
   assign z0_im_o = g_half[0].a_im;
   assign z1_re_o = g_half[1].a_re;
   assign z1_im_o = g_half[1].a_im;
   assign done_o  = done_q;

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   // R5
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (z0_re_o == '0 && z0_im_o == '0 &&
                                z1_re_o == '0 && z1_im_o == '0));
   // R4
   z1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_vld && !s1_half) |=> ($stable(z1_re_o) && $stable(z1_im_o)));
   // R4
   z0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_vld && s1_half) |=> ($stable(z0_re_o) && $stable(z0_im_o)));
   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(z0_re_o) && $stable(z0_im_o) &&
                                 $stable(z1_re_o) && $stable(z1_im_o)));
endmodule

// File: tb/ca_halfburst_corr_test.sv
module ca_halfburst_corr_test;
   localparam int LLR_W = 6, LLR_FRAC = 2, SOFT_W = 8, SYM_W = 10;
   localparam int MAX_LEN = 2048, LEN_W = 12, ACC_W = 29;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [LEN_W-1:0] len_i = '0;
   logic valid_i = 1'b0;
   logic signed [LLR_W-1:0] llr_even_i = '0, llr_odd_i = '0;
   logic signed [SYM_W-1:0] rx_re_i = '0, rx_im_i = '0;
   logic busy_o, done_o, err_o;
   logic signed [ACC_W-1:0] z0_re_o, z0_im_o, z1_re_o, z1_im_o;

   always #5 clk = ~clk;

   ca_halfburst_corr #(.LLR_W(LLR_W), .LLR_FRAC(LLR_FRAC), .SOFT_W(SOFT_W),
                       .SYM_W(SYM_W), .MAX_LEN(MAX_LEN)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
      .valid_i(valid_i), .llr_even_i(llr_even_i), .llr_odd_i(llr_odd_i),
      .rx_re_i(rx_re_i), .rx_im_i(rx_im_i), .busy_o(busy_o), .done_o(done_o),
      .err_o(err_o), .z0_re_o(z0_re_o), .z0_im_o(z0_im_o),
      .z1_re_o(z1_re_o), .z1_im_o(z1_im_o));

   int vectors = 0;
   int miscmp = 0;

   // behavioural reference state
   longint m0r = 0, m0i = 0, m1r = 0, m1i = 0;
   bit m_run = 0, m_done = 0, m_err = 0;
   int m_len = 0, m_idx = 0;
   longint qr[$], qi[$];
   bit qh[$], ql[$];

   function automatic int tq(input int v);
      real y;
      y = $tanh(real'(v) / 8.0) * 127.0;
      if (y >= 0.0) return int'($floor(y + 0.5));
      return -int'($floor(-y + 0.5));
   endfunction

   task automatic chk(input longint act, input longint exp, input string tag);
      vectors++;
      if (act != exp) begin
         miscmp++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cmp_all();
      chk(longint'(busy_o), longint'(m_run || qr.size() > 0), "R10 busy");
      chk(longint'(done_o), longint'(m_done), "R6 done");
      chk(longint'(err_o), longint'(m_err), "R7 err");
      chk(z0_re_o, m0r, "R4 z0_re");
      chk(z0_im_o, m0i, "R4 z0_im");
      chk(z1_re_o, m1r, "R4 z1_re");
      chk(z1_im_o, m1i, "R4 z1_im");
   endtask

   // one clock with the inputs driven at the preceding falling edge
   task automatic cyc();
      bit busy_pre;
      int sr, si, rr, ri;
      busy_pre = m_run || (qr.size() > 0);
      @(posedge clk);
      m_done = 0;
      if (qr.size() > 0) begin
         longint pr, pi;
         bit h, l;
         pr = qr.pop_front(); pi = qi.pop_front();
         h = qh.pop_front(); l = ql.pop_front();
         if (h) begin m1r += pr; m1i += pi; end
         else   begin m0r += pr; m0i += pi; end
         if (l) m_done = 1;
      end
      if (start_i && !busy_pre) begin
         int n;
         n = int'(len_i);
         m0r = 0; m0i = 0; m1r = 0; m1i = 0;
         if (n == 0 || (n % 2) != 0 || n > MAX_LEN) begin
            m_err = 1; m_run = 0;
         end else begin
            m_err = 0; m_run = 1; m_len = n; m_idx = 0;
         end
      end else if (m_run && valid_i) begin
         sr = tq(int'(llr_even_i)); si = tq(int'(llr_odd_i));
         rr = int'(rx_re_i); ri = int'(rx_im_i);
         qr.push_back(longint'(rr * sr + ri * si));
         qi.push_back(longint'(ri * sr - rr * si));
         qh.push_back(m_idx >= m_len / 2);
         ql.push_back(m_idx == m_len - 1);
         if (m_idx == m_len - 1) m_run = 0;
         m_idx++;
      end
      @(negedge clk);
      cmp_all();
   endtask

   task automatic do_start(input int n);
      start_i = 1'b1; len_i = LEN_W'(n);
      cyc();
      start_i = 1'b0;
   endtask

   task automatic sym(input int le, input int lo, input int rr, input int ri);
      valid_i = 1'b1;
      llr_even_i = LLR_W'(le); llr_odd_i = LLR_W'(lo);
      rx_re_i = SYM_W'(rr); rx_im_i = SYM_W'(ri);
      cyc();
      valid_i = 1'b0;
   endtask

   // mode 0 random, 1 random with gaps, 2 full scale, 3 start during burst
   task automatic burst(input int n, input int mode, input string tag);
      do_start(n);
      chk(z0_re_o | z0_im_o | z1_re_o | z1_im_o, 0, "R5 cleared after start");
      for (int i = 0; i < n; i++) begin
         if (mode == 1 && ($urandom % 3) == 0) begin
            valid_i = 1'b0; cyc();
         end
         if (mode == 3 && i == n / 2) begin
            start_i = 1'b1; len_i = LEN_W'(4);
         end
         if (mode == 2) sym(-32, -32, -512, -512);
         else sym(int'($urandom % 64) - 32, int'($urandom % 64) - 32,
                  int'($urandom % 1024) - 512, int'($urandom % 1024) - 512);
         start_i = 1'b0;
      end
      cyc();
      chk(longint'(done_o), 1, {tag, " R6 done after last symbol"});
      chk(longint'(busy_o), 0, {tag, " R10 idle at done"});
      chk(z0_re_o, m0r, {tag, " front real"});
      chk(z1_im_o, m1i, {tag, " rear imag"});
      cyc();
      chk(longint'(done_o), 0, "R6 done single cycle");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      cmp_all();
      chk(longint'(busy_o), 0, "R5 reset busy");
      rst_n = 1'b1;
      cyc();

      // R3 random bursts, several lengths
      burst(8, 0, "R3 L=8");
      burst(2, 0, "R4 L=2 boundary");
      burst(30, 0, "R3 L=30");
      // R1 valid gaps do not advance the burst
      burst(16, 1, "R1 gaps");
      // R8 start while busy ignored
      burst(12, 3, "R8 start during burst");

      // R1 component order, R3 conjugate: rx=(0,1) gives re=si, im=sr
      do_start(2);
      sym(12, -20, 0, 1);
      sym(0, 0, 0, 0);
      cyc();
      chk(z0_re_o, tq(-20), "R1 odd ratio drives imag part");
      chk(z0_im_o, tq(12), "R3 conj product imag");

      // R8 valid while idle has no effect
      begin
         longint s0, s1;
         s0 = z0_im_o; s1 = z0_re_o;
         for (int k = 0; k < 5; k++) sym(31, 31, 511, 511);
         chk(z0_im_o, s0, "R8 idle valid ignored im");
         chk(z0_re_o, s1, "R8 idle valid ignored re");
      end

      // R7 invalid lengths
      do_start(5);
      chk(longint'(err_o), 1, "R7 odd length flagged");
      chk(longint'(busy_o), 0, "R7 odd length no burst");
      do_start(0);
      chk(longint'(err_o), 1, "R7 zero length flagged");
      do_start(MAX_LEN + 2);
      chk(longint'(err_o), 1, "R7 oversize length flagged");
      sym(5, 5, 100, 100);
      chk(z0_re_o, 0, "R7 no accumulation after error");
      burst(4, 0, "R7 recovery");
      chk(longint'(err_o), 0, "R7 err cleared by valid start");

      // R2 every table code, rx=(1,0): re = sr, im = -si
      for (int c = -32; c < 32; c++) begin
         do_start(2);
         sym(c, c, 1, 0);
         sym(0, 0, 0, 0);
         cyc();
         chk(z0_re_o, tq(c), "R2 table real");
         chk(z0_im_o, -tq(c), "R2 table imag");
      end

      // R9 full scale at the maximum length
      burst(MAX_LEN, 2, "R9 full scale");
      chk(z0_re_o, longint'(MAX_LEN / 2) * 2 * 512 * (-tq(-32)), "R9 front no overflow");
      chk(z1_re_o, longint'(MAX_LEN / 2) * 2 * 512 * (-tq(-32)), "R9 rear no overflow");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      miscmp++;
      $display("FAIL R6 watchdog: actual %0d cycles expected fewer", 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
   end
endmodule